// File: doc/BRIEF.md
# Error Interrupt Status Collector

This block gathers six single-cycle error event pulses into a sticky raw status register and derives a masked status from a software-controlled enable mask. From the masked status it drives one combined error interrupt and a separate fatal-class indication. Software works through a simple register port: it sets and clears individual enable bits at two separate addresses, reads raw and masked status at two other addresses, and acknowledges events by writing ones to either status address.

The event bits have fixed meanings. Bit 5 is an end-to-end CRC error, bit 4 a bus tag-lookup fatal error, bit 3 a correctable error, bit 2 a non-fatal error, bit 1 a fatal error and bit 0 a system summary. Bits 1 and 4 form the fatal class. Producing the events is outside the block.

Top module: `err_irq_collector`

## Requirements
- R1: After a synchronous active-low reset, raw status, the enable mask, the interrupt output and the fatal output are all zero.
- R2: An event pulse on bit i of `err_evt_i` sets raw status bit i at the next clock edge whether or not bit i is enabled. The bit stays set until it is cleared, and raw status reads back in bits 5:0 at offset 0x1c0.
- R3: Reading offset 0x1c4 returns raw status ANDed with the enable mask in bits 5:0. All other read data bits are zero.
- R4: Writing to offset 0x1c8 sets every enable bit whose write data bit (5:0) is one and leaves the others unchanged. Writing 0x3f enables all six sources. Reads of offset 0x1c8 or 0x1cc return the enable mask.
- R5: Writing to offset 0x1cc clears every enable bit whose write data bit is one and leaves the others unchanged.
- R6: Writing ones to offset 0x1c0 or 0x1c4 clears the matching raw status bits. Bits written as zero are unchanged.
- R7: An event on a bit in the same cycle as a write-one clear of that bit leaves the bit set.
- R8: `err_irq_o` is high exactly when at least one masked status bit is set.
- R9: `err_fatal_o` is high exactly when masked status bit 1 or bit 4 is set. No other bit drives it.
- R10: Writes to any other address change nothing, and reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_evt_i | input | 6 | Error event pulses, one bit per source |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, valid in the same cycle |
| err_irq_o | output | 1 | Combined error interrupt |
| err_fatal_o | output | 1 | Fatal-class error indication |

## Verification
Events are first injected with every source disabled. This separates the sticky raw capture from the masked view and shows that the interrupt stays quiet. After all sources are enabled, the bench removes the enable of one fatal bit. This shows that fatal follows only the masked bits 1 and 4, while the interrupt still follows the others. A sweep then raises each source alone, so that every bit position is told apart from its neighbours in both the status and the fatal output. Acknowledge writes are sent through both status addresses, once alone and once together with an event on the bit being cleared, to show the priority of set over clear. A write and a read to an unmapped address show that nothing else is decoded.

// File: rtl/err_irq_pkg.sv
// Shared constants for the error interrupt status collector.
// Assumes a byte-addressed register port with 32-bit words.
package err_irq_pkg;
    localparam int N_SRC = 6;

    // Fixed source positions
    localparam int SRC_SYS    = 0;
    localparam int SRC_FATAL  = 1;
    localparam int SRC_NONFAT = 2;
    localparam int SRC_CORR   = 3;
    localparam int SRC_TAGLK  = 4;
    localparam int SRC_ECRC   = 5;

    localparam logic [N_SRC-1:0] FATAL_CLASS = N_SRC'((1 << SRC_FATAL) | (1 << SRC_TAGLK));

    // Register offsets from the block base
    localparam int OFF_RAW    = 'h0;
    localparam int OFF_MASKED = 'h4;
    localparam int OFF_EN_SET = 'h8;
    localparam int OFF_EN_CLR = 'hC;
endpackage

// File: rtl/err_status_bank.sv
// Sticky raw status: one flop per source.
// Assumes events are single-cycle pulses. A set wins over a clear in the same cycle.
module err_status_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] clr,
    output logic [N-1:0] raw_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Capture event, else honour write-one-to-clear
        always_ff @(posedge clk) begin
            if (!rst_n)      raw_q[i] <= 1'b0;
            else if (evt[i]) raw_q[i] <= 1'b1;
            else if (clr[i]) raw_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/err_enable_reg.sv
// Enable mask updated through separate set and clear strobes.
// Assumes set and clear never arrive in the same cycle. If they do, clear wins.
module err_enable_reg #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_m,
    input  logic [N-1:0] clr_m,
    output logic [N-1:0] en_q
);
    // Apply set bits, then clear bits
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= (en_q | set_m) & ~clr_m;
    end
endmodule

// File: rtl/err_irq_combine.sv
// Masks raw status and reduces it to the interrupt and fatal outputs.
// Purely combinational. The fatal class is a fixed bit mask.
module err_irq_combine #(
    parameter int           N     = 6,
    parameter logic [N-1:0] FMASK = '0
) (
    input  logic [N-1:0] raw,
    input  logic [N-1:0] en,
    output logic [N-1:0] masked,
    output logic         irq,
    output logic         fatal
);
    // Gate each source by its enable and reduce
    always_comb begin
        masked = raw & en;
        irq    = |masked;
        fatal  = |(masked & FMASK);
    end
endmodule

// File: rtl/err_irq_collector.sv
// Top level: decodes the register port and wires status, enable and combine.
// Assumes reads return data in the same cycle and that writes take effect at the next edge.
module err_irq_collector
    import err_irq_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'('h1C0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  err_evt_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              err_irq_o,
    output logic              err_fatal_o
);
    localparam logic [ADDR_W-1:0] A_RAW    = BASE_ADDR + ADDR_W'(OFF_RAW);
    localparam logic [ADDR_W-1:0] A_MASKED = BASE_ADDR + ADDR_W'(OFF_MASKED);
    localparam logic [ADDR_W-1:0] A_EN_SET = BASE_ADDR + ADDR_W'(OFF_EN_SET);
    localparam logic [ADDR_W-1:0] A_EN_CLR = BASE_ADDR + ADDR_W'(OFF_EN_CLR);
    localparam int                PAD_W    = DATA_W - N_SRC;

    logic [N_SRC-1:0] raw_q, en_q, masked;
    logic [N_SRC-1:0] stat_clr, en_set, en_clr, wbits;
    logic             hit_stat;
    logic             unused_wdata;

    assign wbits        = bus_wdata_i[N_SRC-1:0];
    assign unused_wdata = ^bus_wdata_i[DATA_W-1:N_SRC];

    // Write decode into per-register bit strobes
    always_comb begin
        hit_stat = bus_wr_i && (bus_addr_i == A_RAW || bus_addr_i == A_MASKED);
        stat_clr = hit_stat ? wbits : '0;
        en_set   = (bus_wr_i && bus_addr_i == A_EN_SET) ? wbits : '0;
        en_clr   = (bus_wr_i && bus_addr_i == A_EN_CLR) ? wbits : '0;
    end

    err_status_bank #(.N(N_SRC)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (err_evt_i),
        .clr   (stat_clr),
        .raw_q (raw_q)
    );

    err_enable_reg #(.N(N_SRC)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .set_m (en_set),
        .clr_m (en_clr),
        .en_q  (en_q)
    );

    err_irq_combine #(.N(N_SRC), .FMASK(FATAL_CLASS)) u_comb (
        .raw    (raw_q),
        .en     (en_q),
        .masked (masked),
        .irq    (err_irq_o),
        .fatal  (err_fatal_o)
    );

    // Read mux; unmapped addresses return zero
    always_comb begin
        unique case (bus_addr_i)
            A_RAW:              bus_rdata_o = {{PAD_W{1'b0}}, raw_q};
            A_MASKED:           bus_rdata_o = {{PAD_W{1'b0}}, masked};
            A_EN_SET, A_EN_CLR: bus_rdata_o = {{PAD_W{1'b0}}, en_q};
            default:            bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/err_irq_collector_chk.sv
// Property checker for err_irq_collector, attached by bind below.
// Observes ports and the raw and enable registers.
module err_irq_collector_chk #(
    parameter int                ADDR_W    = 12,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'('h1C0)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [5:0]        evt,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [5:0]        raw,
    input logic [5:0]        en,
    input logic              irq,
    input logic              fatal
);
    localparam logic [ADDR_W-1:0] A_RAW = BASE_ADDR;
    localparam logic [ADDR_W-1:0] A_MSK = BASE_ADDR + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_SET = BASE_ADDR + ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_CLR = BASE_ADDR + ADDR_W'(12);

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (raw == 6'd0 && en == 6'd0 && !irq && !fatal));
    // R2
    evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != 6'd0) |=> ((raw & $past(evt)) == $past(evt)));
    // R4
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_SET) |=> ((en & $past(wdata[5:0])) == $past(wdata[5:0])));
    // R5
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_CLR) |=> ((en & $past(wdata[5:0])) == 6'd0));
    // R6
    stat_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (addr == A_RAW || addr == A_MSK)) |=> ((raw & $past(wdata[5:0] & ~evt)) == 6'd0));
    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw & en) != 6'd0));
    // R9
    fatal_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |-> irq);
    // R9
    fatal_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & en & 6'b010010) == 6'd0) |-> !fatal);
endmodule

bind err_irq_collector err_irq_collector_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (err_evt_i),
    .wr    (bus_wr_i),
    .addr  (bus_addr_i),
    .wdata (bus_wdata_i),
    .raw   (raw_q),
    .en    (en_q),
    .irq   (err_irq_o),
    .fatal (err_fatal_o)
);

// File: tb/sim_err_irq_collector.sv
// Scoreboard bench: driver tasks queue expected items, a monitor pops and compares.
module sim_err_irq_collector;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_RAW = 12'h1C0, A_MSK = 12'h1C4, A_SET = 12'h1C8, A_CLR = 12'h1CC;

    typedef struct {
        int          kind;   // 0 rdata, 1 irq, 2 fatal
        logic [31:0] exp;
        string       req;
    } item_t;

    logic        clk = 0, rst_n = 0, bus_wr = 0;
    logic [5:0]  evt = '0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq, fatal;

    item_t sb[$];
    event  smp;
    int    n_chk = 0, n_bad = 0;
    bit    done = 0;
    logic [5:0] m_raw = '0, m_en = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    err_irq_collector u0 (
        .clk(clk), .rst_n(rst_n), .err_evt_i(evt), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .err_irq_o(irq), .err_fatal_o(fatal)
    );

    // Monitor: pop the next expectation and compare
    always @(smp) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
            0:       act = bus_rdata;
            1:       act = {31'd0, irq};
            default: act = {31'd0, fatal};
        endcase
        n_chk++;
        if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", it.req, act, it.exp);
        end
    end

    // One bus/event cycle, then update the reference model
    task automatic cyc(input logic wr, input logic [11:0] a, input logic [31:0] d, input logic [5:0] e);
        logic [5:0] clr;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; evt = e;
        @(negedge clk);
        bus_wr = 0; evt = '0;
        clr = (wr && (a == A_RAW || a == A_MSK)) ? d[5:0] : 6'd0;
        m_raw = (m_raw & ~clr) | e;
        if (wr && a == A_SET) m_en = m_en | d[5:0];
        if (wr && a == A_CLR) m_en = m_en & ~d[5:0];
    endtask

    task automatic expect_item(input int kind, input logic [11:0] a, input logic [31:0] exp, input string req);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.kind = kind; it.exp = exp; it.req = req;
        sb.push_back(it);
        #(CLK_PERIOD/4) -> smp;
    endtask

    task automatic check_all(input string req);
        logic [5:0] mk;
        mk = m_raw & m_en;
        expect_item(0, A_RAW, {26'd0, m_raw}, {req, " raw"});
        expect_item(0, A_MSK, {26'd0, mk}, {req, " masked"});
        expect_item(0, A_SET, {26'd0, m_en}, {req, " enable"});
        expect_item(0, A_CLR, {26'd0, m_en}, {req, " enable@clr"});
        expect_item(1, A_RAW, {31'd0, |mk}, {req, " irq"});
        expect_item(2, A_RAW, {31'd0, |(mk & 6'b010010)}, {req, " fatal"});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all("R1 reset");
        // R2: events captured while disabled, interrupt quiet (R8)
        cyc(0, A_RAW, 0, 6'b101010);
        check_all("R2 disabled capture / R8");
        // R4: enable all, R3 masked view, R9 fatal via bit 1
        cyc(1, A_SET, 32'h3F, 0);
        check_all("R4 enable all / R3 / R9");
        // R5: drop enable of bit 1, fatal must fall, irq stays
        cyc(1, A_CLR, 32'h02, 0);
        check_all("R5 clear enable / R9");
        // R6: acknowledge bit 3 via raw address, upper data ignored
        cyc(1, A_RAW, 32'hFFFF_FF08 & 32'hFFFF_FF3F & ~32'h37, 0);
        check_all("R6 w1c raw addr");
        // R9: tag-lookup fatal bit alone
        cyc(0, A_RAW, 0, 6'b010000);
        check_all("R9 fatal bit4");
        // R7: clear bits 5,4 via masked address while bit 4 fires again
        cyc(1, A_MSK, 32'h30, 6'b010000);
        check_all("R7 set beats clear / R6 masked addr");
        // R10: unmapped write and read
        cyc(1, 12'h1D0, 32'hFF, 0);
        check_all("R10 unmapped write");
        expect_item(0, 12'h1D0, 32'd0, "R10 unmapped read");
        // R8: clear everything, irq falls
        cyc(1, A_RAW, 32'h3F, 0);
        check_all("R8 all cleared");
        // Sweep each source alone with all enabled
        cyc(1, A_SET, 32'h3F, 0);
        for (int i = 0; i < 6; i++) begin
            cyc(0, A_RAW, 0, 6'(1 << i));
            check_all($sformatf("R9 R3 sweep bit %0d", i));
            cyc(1, A_MSK, 32'(1 << i), 0);
        end
        check_all("R6 sweep end");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule